// File: doc/BRIEF.md
# HDLC Frame Transmitter with NRZI Line Coding

This block turns a stream of bytes into bit-oriented HDLC/SDLC frames on a single serial line. It reacts to a bit-rate enable: each clock cycle with `bit_en` high puts one line bit out. The producer offers bytes through a valid/ready handshake and marks the last byte of a message with `in_eom`.

When a frame begins, the block sends the opening flag by itself. It also presets the frame check sequence generator and clears the underrun status. No command is needed for any of these. Between the opening and closing flags, the block inserts a zero after every run of five ones in the data and FCS bits. It appends the complemented CRC-CCITT value, then sends the closing flag.

A missing byte at a byte boundary ends the frame as an underrun. An abort request replaces the rest of the frame with a run of ones. The line can be sent as plain NRZ or as NRZI. In NRZI mode the line is held high between frames. The RTS output is released only after the closing flag has fully left the line.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst_n` is low, `txd` is 1, and `rts_out`, `underrun` and `in_ready` are 0.
- R2: A frame starts at the end of an idle flag unit when `rts_req` and `in_valid` are both high. It begins with an opening flag 0x7E, sent before the first data bit, with no other input needed.
- R3: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only in `bit_en` cycles at a byte boundary inside a frame. Data bits go out least significant bit first.
- R4: After the last byte comes the FCS. It is CRC-CCITT (x^16+x^12+x^5+1, reflected register, poly constant 0x8408), preset to 0xFFFF at the start of every frame. It is sent complemented, least significant bit first.
- R5: Within data and FCS bits, a 0 is inserted after every five consecutive 1s. Flags and abort bits are never stuffed.
- R6: A byte taken with `in_eom` high is followed by the FCS and a closing flag 0x7E, and `underrun` stays 0.
- R7: If no byte is offered at a byte boundary inside a frame, `underrun` goes to 1 and the FCS and a closing flag follow. `underrun` returns to 0 when the next frame starts.
- R8: In NRZ mode, the idle line carries back-to-back 0x7E flags, each sent LSB first.
- R9: With `nrzi_mode` high, a 0 bit toggles `txd` and a 1 bit keeps its level. This coding is applied after zero insertion. Outside frames the line is held at 1, from the bit after the closing flag until the opening flag.
- R10: `rts_out` goes to 1 on the clock after `rts_req` goes high. If `rts_req` falls during a frame, `rts_out` stays 1 through the last closing flag bit and drops at the next bit tick.
- R11: An `abort_req` pulse during a frame ends it. The rest of the frame, including the FCS and closing flag, is replaced by eight unstuffed 1 bits, after which idle resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable, one line bit per high cycle |
| in_data | input | BYTE_W | Byte offered by the producer |
| in_valid | input | 1 | `in_data` holds a valid byte |
| in_ready | output | 1 | Byte is taken this cycle if valid |
| in_eom | input | 1 | Offered byte is the last of the message |
| abort_req | input | 1 | Request to abort the frame in progress |
| nrzi_mode | input | 1 | 1 selects NRZI line coding, 0 selects NRZ |
| rts_req | input | 1 | Request to send, enables frame start |
| txd | output | 1 | Serial line output |
| rts_out | output | 1 | Request-to-send output |
| underrun | output | 1 | Last frame ended because data ran out |

## Verification
The bench uses the default parameters: 8-bit bytes, a 16-bit FCS, a stuffing run of five and an eight-bit abort. It pulses `bit_en` every fourth clock, so several clocks separate each bit tick. This exposes `in_ready` being high outside a tick, and lets `rts_out` be sampled exactly at the bit where the closing flag ends.

The bench builds each expected frame from its bytes, including stuffing inside the FCS, and searches the decoded capture for it. With all-ones data, stuffing occurs across byte boundaries. NRZI frames are decoded with the toggle rule before comparison.

// File: rtl/hdlc_tx_pkg.sv
// Package: shared types and constants for the HDLC frame transmitter.
// Assumes frames use a fixed 8-bit flag; everything else is parameterised
// in the modules.
package hdlc_tx_pkg;

    // Unit being serialised by the frame sequencer
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } seq_state_t;

    localparam int          FLAG_LEN     = 8;
    localparam logic [7:0]  FLAG_PATTERN = 8'h7E;

endpackage

// File: rtl/hdlc_fcs_gen.sv
// Module: hdlc_fcs_gen
// Bit-serial CRC register for the frame check sequence. Works in reflected
// (LSB-first) form. It presets at frame start, steps once per data bit, then
// shifts out its contents one bit per FCS bit. Assumes preset, step and
// shift are mutually exclusive in any cycle.
module hdlc_fcs_gen #(
    parameter int               CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY   = 16'h8408,
    parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             step,
    input  logic             step_bit,
    input  logic             shift,
    output logic             fcs_bit,
    output logic [CRC_W-1:0] crc_q
);

    // Remainder register: preset, fold in a data bit, or shift toward the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= PRESET;
        end else if (preset) begin
            crc_q <= PRESET;
        end else if (step) begin
            crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ step_bit) ? POLY : '0);
        end else if (shift) begin
            crc_q <= {1'b1, crc_q[CRC_W-1:1]};
        end
    end

    // The FCS goes out complemented, lowest bit first
    assign fcs_bit = ~crc_q[0];

endmodule

// File: rtl/hdlc_zero_stuffer.sv
// Module: hdlc_zero_stuffer
// Inserts a 0 after RUN consecutive eligible 1 bits. While a zero is
// inserted, the source is held (src_adv low). Ineligible bits (flags,
// abort) clear the run count. Assumes the source changes only when
// src_adv is high.
module hdlc_zero_stuffer #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic src_bit,
    input  logic src_elig,
    output logic out_bit,
    output logic src_adv
);

    localparam int RW = $clog2(RUN + 1);

    logic [RW-1:0] ones_q;
    logic          stuff_now;

    // A full run means the next line bit must be an inserted zero
    assign stuff_now = (ones_q == RW'(RUN));
    assign out_bit   = stuff_now ? 1'b0 : src_bit;
    assign src_adv   = tick && !stuff_now;

    // Count consecutive eligible ones put on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (tick) begin
            if (stuff_now)
                ones_q <= '0;
            else if (src_elig && src_bit)
                ones_q <= ones_q + 1'b1;
            else
                ones_q <= '0;
        end
    end

endmodule

// File: rtl/hdlc_line_coder.sv
// Module: hdlc_line_coder
// Registers the line bit on each tick. In NRZ mode the bit goes out as is.
// In NRZI mode a 0 toggles the level and a 1 keeps it. hold_high forces the
// line to 1. Assumes mode changes happen only between frames.
module hdlc_line_coder (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bit_in,
    input  logic nrzi,
    input  logic hold_high,
    output logic line_q
);

    // Line level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else if (tick) begin
            if (hold_high)
                line_q <= 1'b1;
            else if (nrzi)
                line_q <= bit_in ? line_q : ~line_q;
            else
                line_q <= bit_in;
        end
    end

endmodule

// File: rtl/hdlc_frame_seq.sv
// Module: hdlc_frame_seq
// Frame sequencer. Walks through idle flags, opening flag, data bytes, FCS,
// closing flag and abort. It presents one source bit at a time and moves on
// when the stuffer accepts it (adv). It also owns the byte handshake, the
// underrun latch and the RTS release. Assumes adv is only high on bit ticks.
module hdlc_frame_seq
    import hdlc_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int CRC_W     = 16,
    parameter int ABORT_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_eom,
    input  logic              abort_req,
    input  logic              rts_req,
    input  logic              fcs_bit,
    output logic              src_bit,
    output logic              src_elig,
    output logic              in_ready,
    output logic              crc_preset,
    output logic              crc_step,
    output logic              crc_shift,
    output logic              idle,
    output logic              rts_out,
    output logic              underrun,
    output seq_state_t        state_o
);

    localparam int MAX_A  = (BYTE_W > CRC_W) ? BYTE_W : CRC_W;
    localparam int MAX_B  = (ABORT_LEN > FLAG_LEN) ? ABORT_LEN : FLAG_LEN;
    localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAXLEN);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              eom_q;
    logic              abort_q;
    int                unit_len;
    logic              last;
    logic              frame_live;
    logic              abort_take;
    logic              start_ok;
    logic              load_pt;

    // Length of the unit being sent and whether this is its last bit
    always_comb begin
        case (state_q)
            ST_DATA:  unit_len = BYTE_W;
            ST_FCS:   unit_len = CRC_W;
            ST_ABORT: unit_len = ABORT_LEN;
            default:  unit_len = FLAG_LEN;
        endcase
    end
    assign last = (cnt_q == CNT_W'(unit_len - 1));

    assign frame_live = (state_q == ST_OPEN) || (state_q == ST_DATA) || (state_q == ST_FCS);
    assign abort_take = abort_q && frame_live;
    assign start_ok   = rts_req && in_valid;
    assign load_pt    = (state_q == ST_OPEN) || ((state_q == ST_DATA) && !eom_q);

    // Bit presented to the stuffer and whether it may be stuffed
    always_comb begin
        case (state_q)
            ST_DATA:  src_bit = sh_q[0];
            ST_FCS:   src_bit = fcs_bit;
            ST_ABORT: src_bit = 1'b1;
            default:  src_bit = FLAG_PATTERN[cnt_q[2:0]];
        endcase
    end
    assign src_elig = (state_q == ST_DATA) || (state_q == ST_FCS);

    // Handshake and CRC control strobes
    assign in_ready   = adv && last && !abort_take && load_pt;
    assign crc_preset = adv && last && (state_q == ST_IDLE) && start_ok;
    assign crc_step   = adv && (state_q == ST_DATA);
    assign crc_shift  = adv && (state_q == ST_FCS);
    assign idle       = (state_q == ST_IDLE);
    assign state_o    = state_q;

    // Unit sequencing, byte capture and underrun latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sh_q     <= '0;
            eom_q    <= 1'b0;
            underrun <= 1'b0;
        end else if (adv) begin
            if (abort_take) begin
                state_q <= ST_ABORT;
                cnt_q   <= '0;
            end else if (!last) begin
                cnt_q <= cnt_q + 1'b1;
                if (state_q == ST_DATA)
                    sh_q <= sh_q >> 1;
            end else begin
                cnt_q <= '0;
                case (state_q)
                    ST_IDLE: begin
                        if (start_ok) begin
                            state_q  <= ST_OPEN;
                            underrun <= 1'b0;
                        end
                    end
                    ST_OPEN, ST_DATA: begin
                        if ((state_q == ST_DATA) && eom_q) begin
                            state_q <= ST_FCS;
                        end else if (in_valid) begin
                            sh_q    <= in_data;
                            eom_q   <= in_eom;
                            state_q <= ST_DATA;
                        end else begin
                            underrun <= 1'b1;
                            state_q  <= ST_FCS;
                        end
                    end
                    ST_FCS:   state_q <= ST_CLOSE;
                    default:  state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Pending abort: held until taken, dropped outside a live frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            abort_q <= 1'b0;
        else if (adv && abort_take)
            abort_q <= 1'b0;
        else if (abort_req)
            abort_q <= 1'b1;
        else if (!frame_live)
            abort_q <= 1'b0;
    end

    // RTS rises at once and falls only on a bit tick spent in idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            rts_out <= 1'b0;
        else if (rts_req)
            rts_out <= 1'b1;
        else if (adv && (state_q == ST_IDLE))
            rts_out <= 1'b0;
    end

endmodule

// File: rtl/hdlc_tx_framer.sv
// Module: hdlc_tx_framer (top)
// HDLC frame transmitter: sequencer -> zero stuffer -> NRZ/NRZI line coder,
// with a bit-serial FCS register beside the sequencer. One line bit per
// bit_en cycle. Assumes nrzi_mode changes only between frames.
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int               BYTE_W     = 8,
    parameter int               CRC_W      = 16,
    parameter logic [CRC_W-1:0] CRC_POLY   = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF,
    parameter int               STUFF_RUN  = 5,
    parameter int               ABORT_LEN  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_eom,
    input  logic              abort_req,
    input  logic              nrzi_mode,
    input  logic              rts_req,
    output logic              txd,
    output logic              rts_out,
    output logic              underrun
);

    logic             src_bit;
    logic             src_elig;
    logic             src_adv;
    logic             line_bit;
    logic             fcs_bit;
    logic             crc_preset;
    logic             crc_step;
    logic             crc_shift;
    logic             seq_idle;
    seq_state_t       seq_state;
    logic [CRC_W-1:0] crc_val;

    hdlc_frame_seq #(
        .BYTE_W    (BYTE_W),
        .CRC_W     (CRC_W),
        .ABORT_LEN (ABORT_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (src_adv),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_eom     (in_eom),
        .abort_req  (abort_req),
        .rts_req    (rts_req),
        .fcs_bit    (fcs_bit),
        .src_bit    (src_bit),
        .src_elig   (src_elig),
        .in_ready   (in_ready),
        .crc_preset (crc_preset),
        .crc_step   (crc_step),
        .crc_shift  (crc_shift),
        .idle       (seq_idle),
        .rts_out    (rts_out),
        .underrun   (underrun),
        .state_o    (seq_state)
    );

    hdlc_fcs_gen #(
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY),
        .PRESET (CRC_PRESET)
    ) u_fcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (crc_preset),
        .step     (crc_step),
        .step_bit (src_bit),
        .shift    (crc_shift),
        .fcs_bit  (fcs_bit),
        .crc_q    (crc_val)
    );

    hdlc_zero_stuffer #(
        .RUN (STUFF_RUN)
    ) u_stuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_en),
        .src_bit  (src_bit),
        .src_elig (src_elig),
        .out_bit  (line_bit),
        .src_adv  (src_adv)
    );

    hdlc_line_coder u_coder (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_en),
        .bit_in    (line_bit),
        .nrzi      (nrzi_mode),
        .hold_high (nrzi_mode && seq_idle),
        .line_q    (txd)
    );

endmodule

// File: rtl/hdlc_tx_checker.sv
// Module: hdlc_tx_checker
// Protocol properties of the frame transmitter, bound into the top module.
// Assumes the state and CRC register are observed through the top's
// internal nets.
module hdlc_tx_checker
    import hdlc_tx_pkg::*;
#(
    parameter int               CRC_W  = 16,
    parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             in_ready,
    input  logic             rts_out,
    input  logic             nrzi_mode,
    input  logic             txd,
    input  logic             underrun,
    input  seq_state_t       state,
    input  logic [CRC_W-1:0] crc
);

    // R3: a byte is only taken on a bit tick
    a_r3_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);

    // R3: a byte is only taken inside a frame
    a_r3_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> ((state == ST_OPEN) || (state == ST_DATA)));

    // R4: every frame opens with a preset CRC register
    a_r4_crc_preset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_OPEN) |-> (crc == PRESET));

    // R7: the underrun latch is clear once a new frame opens
    a_r7_underrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_OPEN) |-> !underrun);

    // R9: NRZI idle ticks keep the line high
    a_r9_nrzi_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && nrzi_mode && (state == ST_IDLE)) |=> txd);

    // R10: RTS cannot fall while a frame is still on the line
    a_r10_rts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_out && (state != ST_IDLE)) |=> rts_out);

endmodule

bind hdlc_tx_framer hdlc_tx_checker #(
    .CRC_W  (CRC_W),
    .PRESET (CRC_PRESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .in_ready  (in_ready),
    .rts_out   (rts_out),
    .nrzi_mode (nrzi_mode),
    .txd       (txd),
    .underrun  (underrun),
    .state     (seq_state),
    .crc       (crc_val)
);

// File: tb/test_hdlc_tx_framer.sv
// Directed bench for hdlc_tx_framer. A central negedge process makes the
// bit enable, feeds bytes from a table and captures the line. Scenario
// tasks build the expected frame from the requirements and search the
// capture for it.
module test_hdlc_tx_framer;

    localparam int TICK_DIV = 4;
    localparam int CAP      = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_eom = 1'b0;
    logic       abort_req = 1'b0;
    logic       nrzi_mode = 1'b0;
    logic       rts_req = 1'b0;
    logic       txd;
    logic       rts_out;
    logic       underrun;

    int total = 0;
    int bad = 0;

    logic [7:0] feed_dat [0:15];
    logic       feed_eom [0:15];
    int         feed_n = 0;
    int         feed_i = 0;
    logic       feed_go = 1'b0;
    logic       pend_x = 1'b0;
    int         div = 0;
    logic       en_d = 1'b0;
    int         ready_bad = 0;

    logic raw  [0:CAP-1];
    logic rtsc [0:CAP-1];
    logic dec  [0:CAP-1];
    logic expb [0:1023];
    int   cap_n = 0;
    logic cap_on = 1'b0;
    int   exp_n = 0;
    int   mpos = -1;

    hdlc_tx_framer i_hdlc_tx_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_eom    (in_eom),
        .abort_req (abort_req),
        .nrzi_mode (nrzi_mode),
        .rts_req   (rts_req),
        .txd       (txd),
        .rts_out   (rts_out),
        .underrun  (underrun)
    );

    always #2 clk = ~clk;

    // Bit enable, line capture and byte feeding, all away from the rising edge
    always @(negedge clk) begin
        if (en_d && cap_on && cap_n < CAP) begin
            raw[cap_n]  = txd;
            rtsc[cap_n] = rts_out;
            cap_n++;
        end
        if (pend_x) feed_i++;
        div    = (div == TICK_DIV - 1) ? 0 : div + 1;
        bit_en = (div == 0);
        en_d   = bit_en;
        in_valid = feed_go && (feed_i < feed_n);
        in_data  = in_valid ? feed_dat[feed_i] : 8'h00;
        in_eom   = in_valid ? feed_eom[feed_i] : 1'b0;
        #1;
        pend_x = in_valid && in_ready && rst_n;
        if (in_ready && !bit_en) ready_bad++;
    end

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    // Expected frame: flag, stuffed data and complemented FCS, flag
    task automatic build_exp(input int n);
        logic [15:0] crc;
        logic [7:0]  flag;
        int          run;
        logic        b;
        logic        fb;
        crc   = 16'hFFFF;
        flag  = 8'h7E;
        run   = 0;
        exp_n = 0;
        for (int i = 0; i < 8; i++) begin expb[exp_n] = flag[i]; exp_n++; end
        for (int k = 0; k < n + 2; k++) begin
            for (int i = 0; i < 8; i++) begin
                if (k < n) begin
                    b   = feed_dat[k][i];
                    fb  = crc[0] ^ b;
                    crc = crc >> 1;
                    if (fb) crc = crc ^ 16'h8408;
                end else begin
                    b = 1'b0;
                end
                if (k == n) b = ~crc[i];
                if (k == n + 1) b = ~crc[8 + i];
                expb[exp_n] = b; exp_n++;
                run = b ? run + 1 : 0;
                if (run == 5) begin expb[exp_n] = 1'b0; exp_n++; run = 0; end
            end
        end
        for (int i = 0; i < 8; i++) begin expb[exp_n] = flag[i]; exp_n++; end
    endtask

    // Decode the capture (NRZI: equal level means 1) and find the frame
    task automatic analyse(input logic nrzi);
        logic prev;
        logic hit;
        prev = 1'b1;
        for (int i = 0; i < cap_n; i++) begin
            dec[i] = nrzi ? (raw[i] == prev) : raw[i];
            prev   = raw[i];
        end
        mpos = -1;
        for (int s = 0; s + exp_n <= cap_n && mpos < 0; s++) begin
            hit = 1'b1;
            for (int j = 0; j < exp_n; j++) if (dec[s + j] !== expb[j]) hit = 1'b0;
            if (hit) mpos = s;
        end
    endtask

    // mode 0: plain, 1: drop rts_req after first byte, 2: abort after two bytes
    task automatic run_frame(input logic nrzi, input int n, input int mode);
        @(posedge clk);
        nrzi_mode = nrzi;
        rts_req   = 1'b1;
        wait_ticks(20);
        @(posedge clk);
        cap_n   = 0;
        cap_on  = 1'b1;
        feed_i  = 0;
        feed_n  = n;
        feed_go = 1'b1;
        if (mode == 1) begin
            for (int k = 0; k < 4000 && feed_i < 1; k++) @(negedge clk);
            @(posedge clk);
            rts_req = 1'b0;
        end
        if (mode == 2) begin
            for (int k = 0; k < 4000 && feed_i < 2; k++) @(negedge clk);
            wait_ticks(3);
            @(posedge clk);
            abort_req = 1'b1;
            feed_go   = 1'b0;
            @(posedge clk);
            abort_req = 1'b0;
        end else begin
            for (int k = 0; k < 4000 && feed_i < n; k++) @(negedge clk);
        end
        wait_ticks(80);
        @(posedge clk);
        feed_go = 1'b0;
        cap_on  = 1'b0;
        build_exp(n);
        analyse(nrzi);
    endtask

    task automatic load3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        feed_dat[0] = a; feed_dat[1] = b; feed_dat[2] = c;
        feed_eom[0] = 1'b0; feed_eom[1] = 1'b0; feed_eom[2] = 1'b1;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
        check(rts_out === 1'b0, "R1 rts_out in reset", int'(rts_out), 0);
        check(underrun === 1'b0, "R1 underrun in reset", int'(underrun), 0);
        check(in_ready === 1'b0, "R1 in_ready in reset", int'(in_ready), 0);
        @(posedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_basic;
        int ok;
        load3(8'h12, 8'hA5, 8'h3C);
        run_frame(1'b0, 3, 0);
        check(mpos >= 0, "R2 R3 R4 R6 NRZ frame found", mpos, 0);
        check(underrun === 1'b0, "R6 underrun after eom frame", int'(underrun), 0);
        ok = (mpos >= 0) ? 1 : 0;
        for (int i = 0; i < 16 && mpos >= 0; i++)
            if (dec[mpos + exp_n + i] !== ((i % 8 == 0 || i % 8 == 7) ? 1'b0 : 1'b1)) ok = 0;
        check(ok == 1, "R8 idle flags after frame", ok, 1);
    endtask

    task automatic t_repeat;
        load3(8'h12, 8'hA5, 8'h3C);
        run_frame(1'b0, 3, 0);
        check(mpos >= 0, "R4 second identical frame has same FCS (preset)", mpos, 0);
    endtask

    task automatic t_stuff;
        load3(8'hFF, 8'hFF, 8'h3E);
        run_frame(1'b0, 3, 0);
        check(mpos >= 0, "R5 frame with long ones runs", mpos, 0);
    endtask

    task automatic t_nrzi;
        int hi;
        load3(8'h00, 8'h81, 8'hFF);
        run_frame(1'b1, 3, 0);
        check(mpos >= 0, "R9 R2 NRZI frame decodes", mpos, 0);
        hi = (mpos > 0) ? 1 : 0;
        for (int i = 0; i < mpos; i++) if (raw[i] !== 1'b1) hi = 0;
        check(hi == 1, "R9 line high before opening flag", hi, 1);
        hi = (mpos >= 0) ? 1 : 0;
        for (int i = 0; i < 16 && mpos >= 0; i++) if (raw[mpos + exp_n + i] !== 1'b1) hi = 0;
        check(hi == 1, "R9 line held high after closing flag", hi, 1);
    endtask

    task automatic t_underrun;
        feed_dat[0] = 8'h5A; feed_dat[1] = 8'hC3;
        feed_eom[0] = 1'b0;  feed_eom[1] = 1'b0;
        run_frame(1'b0, 2, 0);
        check(mpos >= 0, "R7 underrun frame closes with FCS", mpos, 0);
        check(underrun === 1'b1, "R7 underrun set", int'(underrun), 1);
        load3(8'h01, 8'h02, 8'h03);
        run_frame(1'b0, 3, 0);
        check(mpos >= 0, "R7 next frame after underrun", mpos, 0);
        check(underrun === 1'b0, "R7 underrun cleared by new frame", int'(underrun), 0);
    endtask

    task automatic t_rts;
        @(posedge clk);
        rts_req = 1'b0;
        wait_ticks(4);
        @(posedge clk);
        rts_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(rts_out === 1'b1, "R10 rts_out follows rts_req", int'(rts_out), 1);
        load3(8'h33, 8'h44, 8'h55);
        run_frame(1'b0, 3, 1);
        check(mpos >= 0, "R10 frame completes after rts drop", mpos, 0);
        if (mpos >= 0) begin
            check(rtsc[mpos + exp_n - 1] === 1'b1, "R10 rts_out high on last flag bit",
                  int'(rtsc[mpos + exp_n - 1]), 1);
            check(rtsc[mpos + exp_n] === 1'b0, "R10 rts_out low on next bit",
                  int'(rtsc[mpos + exp_n]), 0);
        end
    endtask

    task automatic t_abort;
        int run;
        int best;
        int at;
        int fl;
        logic [7:0] w;
        feed_dat[0] = 8'h11; feed_dat[1] = 8'h22; feed_dat[2] = 8'h44; feed_dat[3] = 8'h88;
        feed_eom[0] = 1'b0;  feed_eom[1] = 1'b0;  feed_eom[2] = 1'b0;  feed_eom[3] = 1'b1;
        run_frame(1'b0, 4, 2);
        run = 0; best = 0; at = -1;
        for (int i = 0; i < cap_n; i++) begin
            run = dec[i] ? run + 1 : 0;
            if (run > best) begin best = run; at = i; end
        end
        check(best >= 7, "R11 abort run of ones", best, 8);
        check(mpos < 0, "R11 aborted frame has no FCS and closing flag", mpos, -1);
        fl = 0;
        for (int i = at + 1; i + 8 <= cap_n && at >= 0; i++) begin
            for (int j = 0; j < 8; j++) w[j] = dec[i + j];
            if (w == 8'h7E) fl = 1;
        end
        check(fl == 1, "R11 idle flags resume after abort", fl, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_repeat();
        t_stuff();
        t_nrzi();
        t_underrun();
        t_rts();
        t_abort();
        check(ready_bad == 0, "R3 in_ready only on bit ticks", ready_bad, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule